// File: doc/BRIEF.md
# Input Clock Source Selector with Hold and Calibration Gating

This block chooses which of four reference inputs feeds a clock-multiplier PLL, or puts the loop into digital hold. Two 8-bit control registers sit behind a plain register write/read port: one carries the requested loop-bandwidth code, the other carries a register clock-select field, a force-hold bit and a calibration-squelch bit. The block resolves the active input by priority. Forced hold wins over everything. Below it, a pin-select strap hands the choice to two external select pins. Below that, the register field applies in manual mode, and an externally computed automatic pick applies in any other mode.

The block also drops the output-clock enable while an internal calibration runs, if squelch is requested. It keeps a newly written bandwidth code pending until a calibration-done pulse applies it to the PLL. All outputs are registered.

Top module: `clksel_ctrl`

## Requirements
- R1: After synchronous reset, address 0 reads 0x42 and address 1 reads 0x05. The outputs are then act_sel=0, hold_o=0, out_en=1 and bw_code=4.
- R2: Address 0 holds the bandwidth code in bits 7:4. Address 1 holds the select field in bits 7:6, force-hold in bit 5 and squelch in bit 4. Writes reach only those bits. The low nibble always reads 0x2 at address 0 and 0x5 at address 1, whatever was written.
- R3: While the force-hold bit is 1, hold_o is 1 from the next cycle and act_sel keeps its previous value, whatever the pins, strap, mode or register field say.
- R4: With force-hold 0 and pin_mode 1, act_sel equals sel_pins one cycle later and the register field has no effect.
- R5: With force-hold 0, pin_mode 0 and auto_mode 00, act_sel follows the register field one cycle later. The encoding is 00 for input 1, 01 for input 2, 10 for input 3 and 11 for input 4.
- R6: With force-hold 0, pin_mode 0 and auto_mode other than 00, act_sel equals auto_pick one cycle later.
- R7: out_en is 0 one cycle after cal_active is high while squelch is 1. Otherwise out_en is 1.
- R8: Writing a bandwidth code leaves bw_code unchanged. On the cycle cal_done is high, the written code is loaded, and bw_code shows it from the next cycle.
- R9: reg_rdata reflects reg_addr combinationally, and a written value is readable from the cycle after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | Register address (0 bandwidth, 1 select) |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr |
| pin_mode | input | 1 | Strap: 1 hands selection to sel_pins |
| sel_pins | input | 2 | External select pins |
| auto_mode | input | 2 | Selection mode, 00 is manual |
| auto_pick | input | 2 | Choice of the automatic quality engine |
| cal_active | input | 1 | Internal calibration in progress |
| cal_done | input | 1 | One-cycle calibration completion pulse |
| act_sel | output | 2 | Active input index |
| hold_o | output | 1 | Digital hold flag |
| out_en | output | 1 | Output-clock enable |
| bw_code | output | 4 | Applied loop-bandwidth code |

## Verification
The hardest case is forced hold arriving while the other sources point somewhere new. To check it, the bench must know which input was active just before hold took effect. The sweep walks every combination of strap, pins, mode, automatic pick and register field, first with hold clear and then with hold set. A running expected selection carries the last resolved index into the held phase. The pending bandwidth case is reached by writing each code and confirming the output stays put until a cal_done pulse arrives.

// File: rtl/clksel_pkg.sv
package clksel_pkg;

    localparam int DATA_W = 8;
    localparam int BW_W   = 4;
    localparam int SEL_W  = 2;
    localparam int RSV_W  = DATA_W - BW_W;

    localparam logic [BW_W-1:0]  BW_RST      = 4'h4;
    localparam logic [RSV_W-1:0] BW_RSV_PAT  = 4'h2;
    localparam logic [RSV_W-1:0] SEL_RSV_PAT = 4'h5;

    localparam logic ADDR_BW  = 1'b0;
    localparam logic ADDR_SEL = 1'b1;

    localparam logic [1:0] MODE_MANUAL = 2'b00;

    typedef enum logic [SEL_W-1:0] {
        SRC_IN1 = 2'b00,
        SRC_IN2 = 2'b01,
        SRC_IN3 = 2'b10,
        SRC_IN4 = 2'b11
    } src_e;

    typedef struct packed {
        src_e ksel;
        logic hold;
        logic squelch;
    } sel_ctl_t;

    typedef struct packed {
        logic       pin_mode;
        src_e       pin_pick;
        logic [1:0] mode;
        src_e       auto_pick;
    } sel_in_t;

    localparam sel_ctl_t CTL_RST = '{ksel: SRC_IN1, hold: 1'b0, squelch: 1'b0};

    function automatic src_e pick_source(sel_ctl_t c, sel_in_t i, src_e prev);
        src_e r;
        if (c.hold)                   r = prev;
        else if (i.pin_mode)          r = i.pin_pick;
        else if (i.mode == MODE_MANUAL) r = c.ksel;
        else                          r = i.auto_pick;
        return r;
    endfunction

endpackage

// File: rtl/clksel_regs.sv
module clksel_regs
    import clksel_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output sel_ctl_t          ctl_q,
    output logic [BW_W-1:0]   bw_wr_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q   <= CTL_RST;
            bw_wr_q <= BW_RST;
        end else if (wr_en) begin
            if (addr == ADDR_SEL)
                ctl_q <= sel_ctl_t'(wdata[DATA_W-1 -: 4]);
            else
                bw_wr_q <= wdata[DATA_W-1 -: BW_W];
        end
    end

    always_comb begin
        if (addr == ADDR_SEL)
            rdata = {ctl_q, SEL_RSV_PAT};
        else
            rdata = {bw_wr_q, BW_RSV_PAT};
    end

endmodule

// File: rtl/clksel_route.sv
module clksel_route
    import clksel_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  sel_ctl_t ctl,
    input  sel_in_t  src_in,
    input  logic     cal_active,
    output src_e     act_q,
    output logic     hold_q,
    output logic     en_q
);

    src_e act_d;

    always_comb begin
        act_d = pick_source(ctl, src_in, act_q);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            act_q  <= SRC_IN1;
            hold_q <= 1'b0;
            en_q   <= 1'b1;
        end else begin
            act_q  <= act_d;
            hold_q <= ctl.hold;
            en_q   <= !(ctl.squelch && cal_active);
        end
    end

endmodule

// File: rtl/clksel_bw_apply.sv
module clksel_bw_apply
    import clksel_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic [BW_W-1:0] pending,
    input  logic            cal_done,
    output logic [BW_W-1:0] applied_q
);

    always_ff @(posedge clk) begin
        if (rst)
            applied_q <= BW_RST;
        else if (cal_done)
            applied_q <= pending;
    end

endmodule

// File: rtl/clksel_ctrl.sv
module clksel_ctrl
    import clksel_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        reg_wr,
    input  logic        reg_addr,
    input  logic [7:0]  reg_wdata,
    output logic [7:0]  reg_rdata,
    input  logic        pin_mode,
    input  logic [1:0]  sel_pins,
    input  logic [1:0]  auto_mode,
    input  logic [1:0]  auto_pick,
    input  logic        cal_active,
    input  logic        cal_done,
    output logic [1:0]  act_sel,
    output logic        hold_o,
    output logic        out_en,
    output logic [3:0]  bw_code
);

    sel_ctl_t        ctl_q;
    logic [BW_W-1:0] bw_wr_q;
    sel_in_t         src_in;
    src_e            act_q;

    assign src_in = '{pin_mode: pin_mode, pin_pick: src_e'(sel_pins),
                      mode: auto_mode, auto_pick: src_e'(auto_pick)};

    clksel_regs regs_i (
        .clk(clk), .rst(rst), .wr_en(reg_wr), .addr(reg_addr),
        .wdata(reg_wdata), .rdata(reg_rdata), .ctl_q(ctl_q), .bw_wr_q(bw_wr_q)
    );

    clksel_route route_i (
        .clk(clk), .rst(rst), .ctl(ctl_q), .src_in(src_in),
        .cal_active(cal_active), .act_q(act_q), .hold_q(hold_o), .en_q(out_en)
    );

    clksel_bw_apply bw_i (
        .clk(clk), .rst(rst), .pending(bw_wr_q), .cal_done(cal_done),
        .applied_q(bw_code)
    );

    assign act_sel = act_q;

endmodule

// File: rtl/clksel_ctrl_chk.sv
module clksel_ctrl_chk
    import clksel_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       pin_mode,
    input logic [1:0] sel_pins,
    input logic       cal_active,
    input logic       cal_done,
    input logic [1:0] act_sel,
    input logic       hold_o,
    input logic       out_en,
    input logic [3:0] bw_code,
    input sel_ctl_t   ctl_q,
    input logic [3:0] bw_wr_q
);

    // R3
    hold_flag_chk: assert property (@(posedge clk) disable iff (rst)
        ctl_q.hold |=> hold_o);

    // R3
    hold_keep_chk: assert property (@(posedge clk) disable iff (rst)
        ctl_q.hold |=> $stable(act_sel));

    // R4
    pin_route_chk: assert property (@(posedge clk) disable iff (rst)
        (!ctl_q.hold && pin_mode) |=> act_sel == $past(sel_pins));

    // R7
    squelch_chk: assert property (@(posedge clk) disable iff (rst)
        (ctl_q.squelch && cal_active) |=> !out_en);

    // R7
    no_cal_en_chk: assert property (@(posedge clk) disable iff (rst)
        !cal_active |=> out_en);

    // R8
    bw_pending_chk: assert property (@(posedge clk) disable iff (rst)
        !cal_done |=> $stable(bw_code));

    // R8
    bw_apply_chk: assert property (@(posedge clk) disable iff (rst)
        cal_done |=> bw_code == $past(bw_wr_q));

endmodule

bind clksel_ctrl clksel_ctrl_chk chk_i (
    .clk(clk), .rst(rst), .pin_mode(pin_mode), .sel_pins(sel_pins),
    .cal_active(cal_active), .cal_done(cal_done), .act_sel(act_sel),
    .hold_o(hold_o), .out_en(out_en), .bw_code(bw_code),
    .ctl_q(ctl_q), .bw_wr_q(bw_wr_q)
);

// File: tb/clksel_ctrl_tb_top.sv
module clksel_ctrl_tb_top;

    logic       clk = 1'b0;
    logic       rst;
    logic       reg_wr;
    logic       reg_addr;
    logic [7:0] reg_wdata;
    logic [7:0] reg_rdata;
    logic       pin_mode;
    logic [1:0] sel_pins;
    logic [1:0] auto_mode;
    logic [1:0] auto_pick;
    logic       cal_active;
    logic       cal_done;
    logic [1:0] act_sel;
    logic       hold_o;
    logic       out_en;
    logic [3:0] bw_code;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    clksel_ctrl dut_i (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pin_mode(pin_mode),
        .sel_pins(sel_pins), .auto_mode(auto_mode), .auto_pick(auto_pick),
        .cal_active(cal_active), .cal_done(cal_done), .act_sel(act_sel),
        .hold_o(hold_o), .out_en(out_en), .bw_code(bw_code)
    );

    task automatic check(string req, int actual, int expected);
        checks++;
        if (actual != expected) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, actual, expected);
        end
    endtask

    task automatic wr(input logic a, input logic [7:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [1:0] exp_act;
        logic [3:0] exp_bw;
        rst = 1'b1; reg_wr = 0; reg_addr = 0; reg_wdata = 0;
        pin_mode = 0; sel_pins = 0; auto_mode = 0; auto_pick = 0;
        cal_active = 0; cal_done = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        reg_addr = 0; #1 check("R1 reg0", reg_rdata, 8'h42);
        reg_addr = 1; #1 check("R1 reg1", reg_rdata, 8'h05);
        check("R1 act_sel", act_sel, 0);
        check("R1 hold", hold_o, 0);
        check("R1 out_en", out_en, 1);
        check("R1 bw", bw_code, 4);

        // R2 / R9 reserved bits and readback
        wr(0, 8'hFF);
        reg_addr = 0; #1 check("R2 R9 reg0 ones", reg_rdata, 8'hF2);
        wr(0, 8'h00);
        reg_addr = 0; #1 check("R2 reg0 zeros", reg_rdata, 8'h02);
        wr(1, 8'h0A);
        reg_addr = 1; #1 check("R2 reg1 low", reg_rdata, 8'h05);
        wr(1, 8'hC0);
        reg_addr = 1; #1 check("R9 reg1", reg_rdata, 8'hC5);
        check("R8 bw pending", bw_code, 4);
        @(negedge clk);

        // R3..R6 sweep: hold clear first, then hold set
        exp_act = act_sel;
        for (int h = 0; h < 2; h++)
            for (int pm = 0; pm < 2; pm++)
                for (int sp = 0; sp < 4; sp++)
                    for (int am = 0; am < 4; am++)
                        for (int ap = 0; ap < 4; ap++)
                            for (int ks = 0; ks < 4; ks++) begin
                                pin_mode  = pm[0];
                                sel_pins  = sp[1:0];
                                auto_mode = am[1:0];
                                auto_pick = ap[1:0];
                                wr(1, {ks[1:0], h[0], 1'b0, 4'h0});
                                @(negedge clk);
                                if (h == 0) begin
                                    if (pm == 1)      exp_act = sp[1:0];
                                    else if (am == 0) exp_act = ks[1:0];
                                    else              exp_act = ap[1:0];
                                end
                                if (h == 1)
                                    check("R3 hold act", act_sel, exp_act);
                                else if (pm == 1)
                                    check("R4 pins", act_sel, exp_act);
                                else if (am == 0)
                                    check("R5 register field", act_sel, exp_act);
                                else
                                    check("R6 auto pick", act_sel, exp_act);
                                check("R3 hold flag", hold_o, h);
                            end

        // R7 squelch during calibration
        for (int sq = 0; sq < 2; sq++)
            for (int ca = 0; ca < 2; ca++) begin
                wr(1, {2'b00, 1'b0, sq[0], 4'h0});
                cal_active = ca[0];
                @(negedge clk);
                check("R7 out_en", out_en, (sq == 1 && ca == 1) ? 0 : 1);
                cal_active = 0;
                @(negedge clk);
            end

        // R8 bandwidth applied only by calibration
        exp_bw = bw_code;
        for (int c = 0; c < 16; c++) begin
            wr(0, {c[3:0], 4'h0});
            @(negedge clk);
            check("R8 pending", bw_code, exp_bw);
            reg_addr = 0; #1 check("R9 bw read", reg_rdata, {c[3:0], 4'h2});
            cal_done = 1'b1;
            @(negedge clk);
            cal_done = 1'b0;
            exp_bw = c[3:0];
            check("R8 applied", bw_code, exp_bw);
        end

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule